// File: doc/BRIEF.md
# Per-Timeslot Trunk Conditioning Unit

This block sits between the byte-wide datapath of a 24-channel T1 framer and a serial PCM backplane. It works on one timeslot per clock. Each cycle it takes one received line octet and one backplane transmit octet, both for the same timeslot. It returns a conditioned octet toward the backplane and a conditioned octet toward the line transmitter. The timeslot comes from an internal counter. A frame-sync pulse forces that counter to timeslot 0.

Each timeslot has its own four conditioning enables. In the receive direction, the line octet can be replaced by a global receive conditioning octet, then inverted. In the transmit direction, backplane octets are stored in a per-timeslot transmit memory and read back one frame later. Freezing a timeslot stops backplane data from updating its memory entry and sends the global transmit conditioning octet in its place. Inversion is applied on readout. Software-side writes to the enable array and to the two global octets arrive on a simple write port.

Top module: `tsc_unit`

## Requirements
- R1: The timeslot index is 0 in any cycle where `fsync` is high. Otherwise it is the previous index plus one, wrapping from 23 to 0. `bp_out_slot` carries the index one cycle after its slot cycle, and `tx_line_slot` carries it two cycles after.
- R2: With enable bits 0 and 1 clear, `bp_out_oct` equals the `rx_line_oct` of the slot cycle, one cycle later.
- R3: With enable bit 0 (receive substitute) set and bit 1 clear, `bp_out_oct` equals the receive conditioning octet in effect during the slot cycle.
- R4: Enable bit 1 (receive invert) bitwise-inverts the receive result. This applies to the line octet, or to the conditioning octet when bit 0 is also set.
- R5: In a cycle whose timeslot has enable bit 3 clear, `bp_in_oct` is written to that timeslot's transmit entry. `tx_line_oct`, two cycles after a slot cycle, shows the entry's content as it was before that cycle, which is the previous frame's octet.
- R6: Enable bit 2 (transmit invert) bitwise-inverts `tx_line_oct` for that timeslot.
- R7: With enable bit 3 (transmit freeze) set, `bp_in_oct` does not change the timeslot's entry, and `tx_line_oct` shows the transmit conditioning octet in effect during the slot cycle. After the freeze is cleared, the pre-freeze content is read once more.
- R8: A write to enable entry `cfg_addr` (0 to 23; 24 to 31 ignored), or to either conditioning octet, takes effect from the cycle after the write. A slot cycle that coincides with the write still uses the old value.
- R9: Reset clears all enables and sets both conditioning octets to 8'hFF. Reset also drives both octet outputs to 0 and both slot outputs to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Marks the current cycle as timeslot 0 |
| rx_line_oct | input | 8 | Received line octet for the current timeslot |
| bp_in_oct | input | 8 | Backplane transmit octet for the current timeslot |
| cfg_we | input | 1 | Enable-array write strobe |
| cfg_addr | input | 5 | Timeslot whose enables are written |
| cfg_bits | input | 4 | Enables: bit0 rx substitute, bit1 rx invert, bit2 tx invert, bit3 tx freeze |
| rxc_we | input | 1 | Write strobe for the receive conditioning octet |
| txc_we | input | 1 | Write strobe for the transmit conditioning octet |
| cond_oct | input | 8 | Data for the conditioning octet writes |
| bp_out_oct | output | 8 | Conditioned receive octet toward the backplane |
| bp_out_slot | output | 5 | Timeslot of `bp_out_oct` |
| tx_line_oct | output | 8 | Conditioned transmit octet toward the line |
| tx_line_slot | output | 5 | Timeslot of `tx_line_oct` |

## Verification
Two events can land in the same cycle: a configuration write, and the processing of the timeslot it addresses. The same holds for a conditioning octet write and a slot that substitutes that octet. The bench provokes these collisions by steering `cfg_addr` to the timeslot it predicts for that cycle, and by writing the conditioning octets while substituting timeslots are live. It judges each collision by R8: the coinciding occurrence must use the old value, and the next occurrence the new one. A frozen slot must also keep its old memory entry through that cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Per-timeslot enables; field order gives the bit positions 3..0.
  typedef struct packed {
    logic tx_frz;
    logic tx_inv;
    logic rx_inv;
    logic rx_sub;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

endpackage

// File: rtl/tsc_slot_ctr.sv
module tsc_slot_ctr #(
  parameter int NUM_SLOTS = 24,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  output logic [SW-1:0] cur_slot
);

  localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

  logic [SW-1:0] slot_q;

  always_comb begin
    if (fsync)               cur_slot = '0;
    else if (slot_q == LAST) cur_slot = '0;
    else                     cur_slot = slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= LAST;
    else     slot_q <= cur_slot;
  end

endmodule

// File: rtl/tsc_cfg_array.sv
module tsc_cfg_array #(
  parameter int NUM_SLOTS = 24,
  parameter int CW = tsc_pkg::CFG_W,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [SW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);

  logic [CW-1:0] cfg_q [NUM_SLOTS];

  // Flop array: read is combinational so a same-cycle write is not seen.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rst)                                  cfg_q[i] <= '0;
      else if (wr_en && wr_addr == SW'(i))      cfg_q[i] <= wr_data;
    end
  end

  assign rd_data = cfg_q[rd_addr];

endmodule

// File: rtl/tsc_rx_path.sv
module tsc_rx_path #(
  parameter int NUM_SLOTS = 24,
  parameter int OCT_W = 8,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    slot,
  input  logic [OCT_W-1:0] line_oct,
  input  logic [OCT_W-1:0] cond_oct,
  input  logic             sub_en,
  input  logic             inv_en,
  output logic [OCT_W-1:0] out_oct,
  output logic [SW-1:0]    out_slot
);

  logic [OCT_W-1:0] picked;

  // Substitution first, inversion second.
  always_comb begin
    picked = sub_en ? cond_oct : line_oct;
    if (inv_en) picked = ~picked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_oct  <= '0;
      out_slot <= SW'(NUM_SLOTS - 1);
    end else begin
      out_oct  <= picked;
      out_slot <= slot;
    end
  end

endmodule

// File: rtl/tsc_tx_path.sv
module tsc_tx_path #(
  parameter int NUM_SLOTS = 24,
  parameter int OCT_W = 8,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    slot,
  input  logic [OCT_W-1:0] bp_oct,
  input  logic [OCT_W-1:0] cond_oct,
  input  logic             frz_en,
  input  logic             inv_en,
  output logic [OCT_W-1:0] out_oct,
  output logic [SW-1:0]    out_slot
);

  logic [OCT_W-1:0] mem [NUM_SLOTS];
  logic [OCT_W-1:0] rd_q;
  logic [OCT_W-1:0] cond_q;
  logic             frz_q, inv_q;
  logic [SW-1:0]    slot_q;
  logic [OCT_W-1:0] chosen;

  // Read-first single-port memory; a frozen slot skips its write.
  always_ff @(posedge clk) begin
    rd_q <= mem[slot];
    if (!frz_en) mem[slot] <= bp_oct;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      frz_q  <= 1'b0;
      inv_q  <= 1'b0;
      slot_q <= SW'(NUM_SLOTS - 1);
    end else begin
      cond_q <= cond_oct;
      frz_q  <= frz_en;
      inv_q  <= inv_en;
      slot_q <= slot;
    end
  end

  // Freeze selection first, inversion on readout.
  always_comb begin
    chosen = frz_q ? cond_q : rd_q;
    if (inv_q) chosen = ~chosen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_oct  <= '0;
      out_slot <= SW'(NUM_SLOTS - 1);
    end else begin
      out_oct  <= chosen;
      out_slot <= slot_q;
    end
  end

endmodule

// File: rtl/tsc_unit.sv
module tsc_unit #(
  parameter int NUM_SLOTS = 24,
  parameter int OCT_W = 8,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int CW = tsc_pkg::CFG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  input  logic [OCT_W-1:0] rx_line_oct,
  input  logic [OCT_W-1:0] bp_in_oct,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_addr,
  input  logic [CW-1:0]    cfg_bits,
  input  logic             rxc_we,
  input  logic             txc_we,
  input  logic [OCT_W-1:0] cond_oct,
  output logic [OCT_W-1:0] bp_out_oct,
  output logic [SW-1:0]    bp_out_slot,
  output logic [OCT_W-1:0] tx_line_oct,
  output logic [SW-1:0]    tx_line_slot
);

  logic [SW-1:0]     cur_slot;
  logic [CW-1:0]     cur_cfg;
  tsc_pkg::chan_cfg_t cfg_s;
  logic [OCT_W-1:0]  rx_cond_q, tx_cond_q;
  logic              wr_ok;

  assign wr_ok = cfg_we && (cfg_addr < SW'(NUM_SLOTS));
  assign cfg_s = tsc_pkg::chan_cfg_t'(cur_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cond_q <= '1;
      tx_cond_q <= '1;
    end else begin
      if (rxc_we) rx_cond_q <= cond_oct;
      if (txc_we) tx_cond_q <= cond_oct;
    end
  end

  tsc_slot_ctr #(.NUM_SLOTS(NUM_SLOTS)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .fsync    (fsync),
    .cur_slot (cur_slot)
  );

  tsc_cfg_array #(.NUM_SLOTS(NUM_SLOTS), .CW(CW)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok),
    .wr_addr (cfg_addr),
    .wr_data (cfg_bits),
    .rd_addr (cur_slot),
    .rd_data (cur_cfg)
  );

  tsc_rx_path #(.NUM_SLOTS(NUM_SLOTS), .OCT_W(OCT_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .slot     (cur_slot),
    .line_oct (rx_line_oct),
    .cond_oct (rx_cond_q),
    .sub_en   (cfg_s.rx_sub),
    .inv_en   (cfg_s.rx_inv),
    .out_oct  (bp_out_oct),
    .out_slot (bp_out_slot)
  );

  tsc_tx_path #(.NUM_SLOTS(NUM_SLOTS), .OCT_W(OCT_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .slot     (cur_slot),
    .bp_oct   (bp_in_oct),
    .cond_oct (tx_cond_q),
    .frz_en   (cfg_s.tx_frz),
    .inv_en   (cfg_s.tx_inv),
    .out_oct  (tx_line_oct),
    .out_slot (tx_line_slot)
  );

endmodule

// File: rtl/tsc_unit_chk.sv
module tsc_unit_chk #(
  parameter int NUM_SLOTS = 24,
  parameter int OCT_W = 8,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input logic             clk,
  input logic             rst,
  input logic             fsync,
  input logic [OCT_W-1:0] rx_line_oct,
  input logic [3:0]       cur_cfg,
  input logic [OCT_W-1:0] rx_cond_q,
  input logic [OCT_W-1:0] tx_cond_q,
  input logic [OCT_W-1:0] bp_out_oct,
  input logic [SW-1:0]    bp_out_slot,
  input logic [OCT_W-1:0] tx_line_oct,
  input logic [SW-1:0]    tx_line_slot
);

  localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

  // R1
  sync_zero_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> bp_out_slot == '0);

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    !fsync |=> bp_out_slot == (($past(bp_out_slot) == LAST) ? '0 : $past(bp_out_slot) + 1'b1));

  // R1
  tx_slot_lag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tx_line_slot == $past(bp_out_slot));

  // R2
  rx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_cfg[1:0] == 2'b00) |=> bp_out_oct == $past(rx_line_oct));

  // R3
  rx_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_cfg[1:0] == 2'b01) |=> bp_out_oct == $past(rx_cond_q));

  // R4
  rx_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_cfg[1:0] == 2'b10) |=> bp_out_oct == ~$past(rx_line_oct));

  // R4
  rx_sub_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_cfg[1:0] == 2'b11) |=> bp_out_oct == ~$past(rx_cond_q));

  // R7
  tx_frz_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_cfg[3:2] == 2'b10) |=> ##1 tx_line_oct == $past(tx_cond_q, 2));

  // R6
  tx_frz_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_cfg[3:2] == 2'b11) |=> ##1 tx_line_oct == ~$past(tx_cond_q, 2));

endmodule

bind tsc_unit tsc_unit_chk #(.NUM_SLOTS(NUM_SLOTS), .OCT_W(OCT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fsync        (fsync),
  .rx_line_oct  (rx_line_oct),
  .cur_cfg      (cur_cfg),
  .rx_cond_q    (rx_cond_q),
  .tx_cond_q    (tx_cond_q),
  .bp_out_oct   (bp_out_oct),
  .bp_out_slot  (bp_out_slot),
  .tx_line_oct  (tx_line_oct),
  .tx_line_slot (tx_line_slot)
);

// File: tb/tb_tsc_unit.sv
`timescale 1ns/1ps
module tb_tsc_unit;

  localparam int N = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0;
  logic [7:0] rx_line_oct = '0, bp_in_oct = '0, cond_oct = '0;
  logic       cfg_we = 1'b0, rxc_we = 1'b0, txc_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [3:0] cfg_bits = '0;
  logic [7:0] bp_out_oct, tx_line_oct;
  logic [4:0] bp_out_slot, tx_line_slot;

  always #4 clk = ~clk;

  tsc_unit dut (
    .clk(clk), .rst(rst), .fsync(fsync),
    .rx_line_oct(rx_line_oct), .bp_in_oct(bp_in_oct),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_bits(cfg_bits),
    .rxc_we(rxc_we), .txc_we(txc_we), .cond_oct(cond_oct),
    .bp_out_oct(bp_out_oct), .bp_out_slot(bp_out_slot),
    .tx_line_oct(tx_line_oct), .tx_line_slot(tx_line_slot)
  );

  typedef struct {
    logic [7:0] oct;
    int         slot;
    bit         chk;
    string      tag;
  } exp_t;

  exp_t       rxq[$];
  exp_t       txq[$];
  logic [3:0] m_cfg [N];
  logic [7:0] m_mem [N];
  bit         m_val [N];
  logic [7:0] m_rxc, m_txc;
  int         m_prev;
  int         n_chk = 0, n_fail = 0;
  int         cyc_in_frame = 0;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int next_slot(bit fs);
    if (fs) return 0;
    return (m_prev == N - 1) ? 0 : m_prev + 1;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    fsync = 0; cfg_we = 0; rxc_we = 0; txc_we = 0;
    rxq.delete(); txq.delete();
    for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_val[i] = 0; end
    m_rxc = 8'hFF; m_txc = 8'hFF; m_prev = N - 1;
    repeat (3) @(negedge clk);
    check("R9", "bp_out_oct", bp_out_oct, 0);
    check("R9", "tx_line_oct", tx_line_oct, 0);
    check("R9", "bp_out_slot", bp_out_slot, N - 1);
    check("R9", "tx_line_slot", tx_line_slot, N - 1);
    rst = 1'b0;
    cyc_in_frame = 0;
  endtask

  // One slot cycle: compare due outputs, drive inputs, advance the model.
  task automatic step(bit fs, logic [7:0] rxd, logic [7:0] bpd,
                      bit cwe, int caddr, logic [3:0] cbits,
                      bit rwe, bit twe, logic [7:0] cd);
    exp_t e;
    int   s;
    logic [3:0] c;
    if (rxq.size() > 0) begin
      e = rxq.pop_front();
      check("R1", "bp_out_slot", bp_out_slot, e.slot);
      check(e.tag, "bp_out_oct", bp_out_oct, e.oct);
    end
    if (txq.size() >= 2) begin
      e = txq.pop_front();
      check("R1", "tx_line_slot", tx_line_slot, e.slot);
      if (e.chk) check(e.tag, "tx_line_oct", tx_line_oct, e.oct);
    end
    fsync = fs; rx_line_oct = rxd; bp_in_oct = bpd;
    cfg_we = cwe; cfg_addr = caddr[4:0]; cfg_bits = cbits;
    rxc_we = rwe; txc_we = twe; cond_oct = cd;

    s = next_slot(fs);
    m_prev = s;
    c = m_cfg[s];
    e.slot = s; e.chk = 1;
    e.oct = c[0] ? m_rxc : rxd;
    if (c[1]) e.oct = ~e.oct;
    if ((cwe && caddr == s) || (rwe && c[0])) e.tag = "R8";
    else e.tag = c[1] ? "R4" : (c[0] ? "R3" : "R2");
    rxq.push_back(e);

    e.chk = c[3] || m_val[s];
    e.oct = c[3] ? m_txc : m_mem[s];
    if (c[2]) e.oct = ~e.oct;
    if ((cwe && caddr == s) || (twe && c[3])) e.tag = "R8";
    else e.tag = c[3] ? "R7" : (c[2] ? "R6" : "R5");
    txq.push_back(e);

    if (!c[3]) begin m_mem[s] = bpd; m_val[s] = 1; end
    if (cwe && caddr < N) m_cfg[caddr] = cbits;
    if (rwe) m_rxc = cd;
    if (twe) m_txc = cd;
    @(negedge clk);
  endtask

  task automatic plain(int cycles);
    for (int i = 0; i < cycles; i++) begin
      step(cyc_in_frame == 0, 8'($urandom), 8'($urandom), 0, 0, 4'h0, 0, 0, 8'h00);
      cyc_in_frame = (cyc_in_frame + 1) % N;
    end
  endtask

  task automatic program_all(int offset);
    for (int i = 0; i < N; i++) begin
      step(cyc_in_frame == 0, 8'($urandom), 8'($urandom),
           1, (i * 5) % N, 4'((i * 5 + offset) % 16), 0, 0, 8'h00);
      cyc_in_frame = (cyc_in_frame + 1) % N;
    end
  endtask

  task automatic mixed(int cycles);
    for (int i = 0; i < cycles; i++) begin
      bit   fs, cwe;
      int   ad;
      fs  = (cyc_in_frame == 0) || ($urandom % 97 == 0);
      if (fs) cyc_in_frame = 0;
      cwe = ($urandom % 4 == 0);
      ad  = ($urandom % 8 == 0) ? next_slot(fs) : int'($urandom % 32);
      step(fs, 8'($urandom), 8'($urandom), cwe, ad, 4'($urandom),
           $urandom % 16 == 0, $urandom % 16 == 0, 8'($urandom));
      cyc_in_frame = (cyc_in_frame + 1) % N;
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R2, R5: plain pass-through in both directions
    plain(3 * N);
    // R9 via R3: substitution right after reset yields 8'hFF
    for (int i = 0; i < N; i++) begin
      step(cyc_in_frame == 0, 8'($urandom), 8'($urandom), 1, i, 4'b0001, 0, 0, 8'h00);
      cyc_in_frame = (cyc_in_frame + 1) % N;
    end
    plain(N);
    // Conditioning octets written, then all 16 enable combinations
    step(0, 8'h3C, 8'h5A, 0, 0, 4'h0, 1, 0, 8'hA5); cyc_in_frame = (cyc_in_frame + 1) % N;
    step(0, 8'h3C, 8'h5A, 0, 0, 4'h0, 0, 1, 8'h69); cyc_in_frame = (cyc_in_frame + 1) % N;
    program_all(0);
    plain(3 * N);
    program_all(8);
    plain(3 * N);
    // R7: freeze all, run, then release and re-read held entries
    for (int i = 0; i < N; i++) begin
      step(cyc_in_frame == 0, 8'($urandom), 8'($urandom), 1, i, 4'b1000, 0, 0, 8'h00);
      cyc_in_frame = (cyc_in_frame + 1) % N;
    end
    plain(2 * N);
    for (int i = 0; i < N; i++) begin
      step(cyc_in_frame == 0, 8'($urandom), 8'($urandom), 1, i, 4'b0100, 0, 0, 8'h00);
      cyc_in_frame = (cyc_in_frame + 1) % N;
    end
    plain(2 * N);
    // R8 collisions and R1 early syncs under random traffic
    mixed(60 * N);
    // Reset mid-run and resume
    do_reset();
    plain(N);
    mixed(20 * N);
    repeat (3) step(0, 8'h00, 8'h00, 0, 0, 4'h0, 0, 0, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule